// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counting timer for a processor subsystem. A 24-bit count register is decremented on each tick. When it steps from one to zero, the block sets a sticky status flag and, if software has allowed it, raises a one-cycle interrupt pulse toward the interrupt controller. The count stays at zero for one full tick. It is then refilled from the reload register, so a reload value of N gives a period of N+1 ticks.

Software reaches four word registers through a simple single-cycle register port. The port uses a select, a write strobe, a byte address and 32-bit data, and read data is combinational. The tick source is chosen by a control bit. It is either every core clock, or only those core cycles where an externally generated reference enable is high. A zero reload value turns the next expiry into a stop, while the run bit stays set. Writing the current-value register forces the count to zero without counting as an expiry.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers all read zero, no interrupt pulse is present, and the timer does not count.
- R2: A control write stores only data bits [2:0]: bit 0 = run, bit 1 = interrupt enable, bit 2 = tick source. All other written bits are ignored. A control read returns those three bits in [2:0], the count flag in bit 16, and zero elsewhere.
- R3: A control read returns the count flag and clears it at that clock edge. If an expiry happens on the same edge, the flag stays set.
- R4: A reload write (offset 0x4) keeps data bits [23:0]. A reload read returns them with bits [31:24] zero.
- R5: Any write to the current-value register (offset 0x8) sets the count to zero and clears the count flag. It raises no interrupt pulse and does not set the flag.
- R6: With tick source 1 a tick happens on every clock while running. With tick source 0 a tick happens only on clocks where `ref_tick_en` is high. A current-value read (offset 0x8) returns the count in bits [23:0] with bits [31:24] zero.
- R7: A tick that moves the count from 1 to 0 sets the count flag. If interrupt enable is 1, `tick_irq` is high for exactly the one cycle after that edge; otherwise it stays low.
- R8: A tick with the count at zero loads the reload value, so zero is held for one full tick before the reload.
- R9: If the count reaches zero while the reload value is zero, counting stops and the run bit still reads 1. Changing the reload value does not restart the timer. Counting resumes only when a control write changes the run bit from 0 to 1.
- R10: The calibration register (offset 0xC) reads the constant 10000. Every other address, including unaligned ones and anything at or above 0x10, reads zero, and writes to it change no register.
- R11: Clearing the run bit freezes the count. Setting it again resumes counting from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_tick_en | input | 1 | Reference tick enable, one core cycle wide per reference period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| tick_irq | output | 1 | One-cycle expiry interrupt pulse |

## Verification
Assertions check on every cycle that the interrupt is a single-cycle pulse that only appears with the count at zero and the flag set. They also check that a zero count is followed by a reload, that a halted or stopped timer keeps its count, that a current-value write leaves zero with the flag cleared, and that reload writes are truncated to 24 bits. Other behaviour needs scenarios that only the bench builds. These are the exact read-back sequence around an expiry, read-to-clear racing an expiry, gating by the reference enable, restart after a zero-reload halt, and resuming from a frozen value. The bench covers them with directed cases and then long random register traffic compared against a model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned WORD_W = 32;

  // Register slots, selected by byte address bits [3:2]
  typedef enum logic [1:0] {
    SLOT_CTRL   = 2'd0,
    SLOT_RELOAD = 2'd1,
    SLOT_COUNT  = 2'd2,
    SLOT_CAL    = 2'd3
  } slot_e;

  // Writable control bits: [0] run, [1] irq enable, [2] tick source
  typedef struct packed {
    logic clk_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned CAL_VAL  = 10000,
  parameter int unsigned FLAG_POS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              run_rise,
  output logic              count_clear,
  output logic              flag_rd
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic             hit;
  slot_e            slot;
  logic             wr_ctrl, wr_reload;
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] reload_d;

  // Address decode: word aligned, inside the 16-byte window
  always_comb begin
    hit         = bus_sel && (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:4] == '0);
    slot        = slot_e'(bus_addr[3:2]);
    wr_ctrl     = hit &&  bus_wr && (slot == SLOT_CTRL);
    wr_reload   = hit &&  bus_wr && (slot == SLOT_RELOAD);
    count_clear = hit &&  bus_wr && (slot == SLOT_COUNT);
    flag_rd     = hit && !bus_wr && (slot == SLOT_CTRL);
    run_rise    = wr_ctrl && bus_wdata[0] && !ctrl.run;
  end

  // Next state
  always_comb begin
    ctrl_d   = ctrl;
    reload_d = reload;
    if (wr_ctrl)   ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (wr_reload) reload_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl)   ctrl   <= ctrl_d;
      if (wr_reload) reload <= reload_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      unique case (slot)
        SLOT_CTRL: begin
          bus_rdata[CTRL_W-1:0] = ctrl;
          bus_rdata[FLAG_POS]   = flag;
        end
        SLOT_RELOAD: bus_rdata[CNT_W-1:0] = reload;
        SLOT_COUNT:  bus_rdata[CNT_W-1:0] = count;
        SLOT_CAL:    bus_rdata = WORD_W'(CAL_VAL);
        default:     bus_rdata = '0;
      endcase
    end
  end

  // R4: reload keeps the low bits of the written word
  p_reload_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> reload == $past(bus_wdata[CNT_W-1:0]));

  // R2: control write of run bit changes run, other bits do not leak
  p_ctrl_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl == $past(bus_wdata[CTRL_W-1:0]));

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick_en,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             run_rise,
  input  logic             count_clear,
  input  logic             flag_rd,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             tick_irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             tick;
  logic             cnt_ce;
  logic [CNT_W-1:0] cnt_d;
  logic             halted_q, halted_d;
  logic             flag_d;
  logic             irq_d;
  logic             reload_zero;

  assign reload_zero = (reload == '0);
  assign tick   = ctrl.run && !halted_q && (ctrl.clk_core || ref_tick_en);
  assign cnt_ce = tick || count_clear;

  always_comb begin
    cnt_d    = count;
    halted_d = halted_q;
    flag_d   = flag;
    irq_d    = 1'b0;
    if (flag_rd)  flag_d   = 1'b0;
    if (run_rise) halted_d = 1'b0;
    if (count_clear) begin
      cnt_d  = '0;
      flag_d = 1'b0;
      if (reload_zero) halted_d = 1'b1;
    end else if (tick) begin
      if (count == ONE) begin
        cnt_d  = '0;
        flag_d = 1'b1;
        irq_d  = ctrl.irq_en;
        if (reload_zero) halted_d = 1'b1;
      end else if (count == '0) begin
        if (reload_zero) halted_d = 1'b1;
        else             cnt_d    = reload;
      end else begin
        cnt_d = count - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      halted_q <= 1'b0;
      flag     <= 1'b0;
      tick_irq <= 1'b0;
    end else begin
      if (cnt_ce) count <= cnt_d;
      halted_q <= halted_d;
      flag     <= flag_d;
      tick_irq <= irq_d;
    end
  end

  // R7: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);

  // R7: pulse only alongside a zero count and a set flag
  p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (count == '0) && flag);

  // R8: zero is followed by the reload value on the next tick
  p_reload_after_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !count_clear && (count == '0) && !reload_zero) |=> count == $past(reload));

  // R9: a halted timer keeps its count
  p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !count_clear) |=> $stable(count));

  // R11: a stopped timer keeps its count
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !count_clear) |=> $stable(count));

  // R5: forced zero clears the flag and raises no pulse
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |=> (count == '0) && !flag && !tick_irq);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned CAL_VAL  = 10000,
  parameter int unsigned FLAG_POS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              tick_irq
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             flag;
  logic             run_rise;
  logic             count_clear;
  logic             flag_rd;

  tick_timer_regs #(
    .AW(AW), .CNT_W(CNT_W), .CAL_VAL(CAL_VAL), .FLAG_POS(FLAG_POS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .flag(flag),
    .ctrl(ctrl), .reload(reload),
    .run_rise(run_rise), .count_clear(count_clear), .flag_rd(flag_rd)
  );

  tick_timer_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .ref_tick_en(ref_tick_en),
    .ctrl(ctrl), .reload(reload),
    .run_rise(run_rise), .count_clear(count_clear), .flag_rd(flag_rd),
    .count(count), .flag(flag), .tick_irq(tick_irq)
  );

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        ref_tick_en;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int n_checks = 0;
  int n_fail   = 0;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_en(ref_tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic [2:0]  m_ctrl;
  logic [23:0] m_rel;
  logic [23:0] m_cnt;
  logic        m_halt;
  logic        m_flag;
  logic        m_irq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [5:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] == 2'b00 && a[5:4] == 2'b00) begin
      case (a[3:2])
        2'd0: begin r[2:0] = m_ctrl; r[16] = m_flag; end
        2'd1: r[23:0] = m_rel;
        2'd2: r[23:0] = m_cnt;
        default: r = 32'd10000;
      endcase
    end
    return r;
  endfunction

  task automatic model_update(input logic sel, input logic wr, input logic [5:0] a,
                              input logic [31:0] wd, input logic rf);
    logic hit, tk, rel0;
    hit  = sel && a[1:0] == 2'b00 && a[5:4] == 2'b00;
    rel0 = (m_rel == 24'd0);
    tk   = m_ctrl[0] && !m_halt && (m_ctrl[2] || rf);
    m_irq = 1'b0;
    if (hit && !wr && a[3:2] == 2'd0) m_flag = 1'b0;
    if (hit && wr && a[3:2] == 2'd2) begin
      m_cnt = '0; m_flag = 1'b0;
      if (rel0) m_halt = 1'b1;
    end else if (tk) begin
      if (m_cnt == 24'd1) begin
        m_cnt = '0; m_flag = 1'b1; m_irq = m_ctrl[1];
        if (rel0) m_halt = 1'b1;
      end else if (m_cnt == 24'd0) begin
        if (rel0) m_halt = 1'b1; else m_cnt = m_rel;
      end else begin
        m_cnt = m_cnt - 24'd1;
      end
    end
    if (hit && wr && a[3:2] == 2'd0) begin
      if (wd[0] && !m_ctrl[0]) m_halt = 1'b0;
      m_ctrl = wd[2:0];
    end
    if (hit && wr && a[3:2] == 2'd1) m_rel = wd[23:0];
  endtask

  // One bus cycle: check the pulse, drive, check read data, advance the model
  task automatic step(input logic sel, input logic wr, input logic [5:0] a,
                      input logic [31:0] wd, input logic rf, input string tag,
                      output logic [31:0] got);
    logic [31:0] e;
    @(negedge clk);
    chk(tick_irq === m_irq, "R7 irq", {31'd0, tick_irq}, {31'd0, m_irq});
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; ref_tick_en = rf;
    #1;
    got = bus_rdata;
    if (sel && !wr) begin
      e = exp_rdata(a);
      chk(got === e, tag, got, e);
    end
    @(posedge clk);
    model_update(sel, wr, a, wd, rf);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
    logic [31:0] g;
    step(1'b1, 1'b1, a, d, 1'b0, tag, g);
  endtask

  task automatic rd(input logic [5:0] a, input logic rf, input string tag, output logic [31:0] g);
    step(1'b1, 1'b0, a, 32'd0, rf, tag, g);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] g, g2, v;
    void'($urandom(32'd20240611));
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; ref_tick_en = 0;
    rst_n = 0;
    m_ctrl = '0; m_rel = '0; m_cnt = '0; m_halt = 0; m_flag = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd(6'h00, 1'b1, "R1 ctrl", g);   chk(g == 32'h0, "R1 ctrl", g, 32'h0);
    rd(6'h04, 1'b1, "R1 reload", g); chk(g == 32'h0, "R1 reload", g, 32'h0);
    rd(6'h08, 1'b1, "R1 count", g);  chk(g == 32'h0, "R1 count", g, 32'h0);

    // R10: calibration and undefined addresses
    rd(6'h0C, 1'b0, "R10 cal", g);   chk(g == 32'd10000, "R10 cal", g, 32'd10000);
    wr(6'h10, 32'hFFFF_FFFF, "R10");
    wr(6'h01, 32'hFFFF_FFFF, "R10");
    rd(6'h10, 1'b0, "R10 undef", g); chk(g == 32'h0, "R10 undef", g, 32'h0);
    rd(6'h02, 1'b0, "R10 unalig", g); chk(g == 32'h0, "R10 unalig", g, 32'h0);
    rd(6'h00, 1'b0, "R10 ctrl", g);  chk(g == 32'h0, "R10 ctrl untouched", g, 32'h0);

    // R2: only low control bits stored
    wr(6'h00, 32'hFFFF_FFF8, "R2");
    rd(6'h00, 1'b0, "R2 ctrl", g);   chk(g == 32'h0, "R2 ctrl", g, 32'h0);

    // R4: reload truncation
    wr(6'h04, 32'hAB12_3456, "R4");
    rd(6'h04, 1'b0, "R4 reload", g); chk(g == 32'h0012_3456, "R4 reload", g, 32'h0012_3456);

    // R8: zero held one tick, then reload (reload 2, core clock, irq on)
    wr(6'h04, 32'd2, "R8");
    wr(6'h08, 32'd5, "R5");
    wr(6'h00, 32'd7, "R8");
    rd(6'h08, 1'b0, "R8 seq", g); chk(g == 32'd0, "R8 seq0", g, 32'd0);
    rd(6'h08, 1'b0, "R8 seq", g); chk(g == 32'd2, "R8 seq1", g, 32'd2);
    rd(6'h08, 1'b0, "R8 seq", g); chk(g == 32'd1, "R8 seq2", g, 32'd1);
    rd(6'h08, 1'b0, "R8 seq", g); chk(g == 32'd0, "R8 seq3", g, 32'd0);
    chk(tick_irq === 1'b1, "R7 pulse after expiry", {31'd0, tick_irq}, 32'd1);
    rd(6'h08, 1'b0, "R8 seq", g); chk(g == 32'd2, "R8 seq4", g, 32'd2);

    // R3: flag read returns then clears (counter stopped first)
    wr(6'h00, 32'd4, "R11");
    rd(6'h00, 1'b0, "R3 flag", g);  chk(g == 32'h0001_0004, "R3 flag set", g, 32'h0001_0004);
    rd(6'h00, 1'b0, "R3 flag", g);  chk(g == 32'h0000_0004, "R3 flag cleared", g, 32'h0000_0004);

    // R11: freeze and resume
    rd(6'h08, 1'b0, "R11 frz", v);
    rd(6'h08, 1'b0, "R11 frz", g2); chk(g2 == v, "R11 frozen", g2, v);
    wr(6'h00, 32'd5, "R11");
    rd(6'h08, 1'b0, "R11 resume", g); chk(g == v, "R11 resume value", g, v);

    // R9: zero reload halts with run still set
    wr(6'h04, 32'd0, "R9");
    repeat (6) step(1'b0, 1'b0, 6'h00, 32'd0, 1'b0, "R9", g);
    rd(6'h08, 1'b0, "R9 cnt", g);  chk(g == 32'd0, "R9 halted count", g, 32'd0);
    rd(6'h00, 1'b0, "R9 ctrl", g); chk(g[0] == 1'b1, "R9 run kept", g, 32'd1);
    wr(6'h04, 32'd3, "R9");
    repeat (2) step(1'b0, 1'b0, 6'h00, 32'd0, 1'b0, "R9", g);
    rd(6'h08, 1'b0, "R9 cnt", g);  chk(g == 32'd0, "R9 still halted", g, 32'd0);
    wr(6'h00, 32'd4, "R9");
    wr(6'h00, 32'd5, "R9");
    rd(6'h08, 1'b0, "R9 cnt", g);  chk(g == 32'd0, "R9 restart zero", g, 32'd0);
    rd(6'h08, 1'b0, "R9 cnt", g);  chk(g == 32'd3, "R9 restart reload", g, 32'd3);

    // R6: reference-enable gating
    wr(6'h00, 32'd1, "R6");
    wr(6'h08, 32'd0, "R6");
    rd(6'h08, 1'b0, "R6 gate", g); chk(g == 32'd0, "R6 gate a", g, 32'd0);
    rd(6'h08, 1'b0, "R6 gate", g); chk(g == 32'd0, "R6 gate b", g, 32'd0);
    rd(6'h08, 1'b1, "R6 gate", g); chk(g == 32'd0, "R6 gate c", g, 32'd0);
    rd(6'h08, 1'b0, "R6 gate", g); chk(g == 32'd3, "R6 gate d", g, 32'd3);
    rd(6'h08, 1'b1, "R6 gate", g); chk(g == 32'd3, "R6 gate e", g, 32'd3);
    rd(6'h08, 1'b0, "R6 gate", g); chk(g == 32'd2, "R6 gate f", g, 32'd2);

    // R5: forced zero clears flag, no pulse
    wr(6'h00, 32'd7, "R5");
    repeat (4) step(1'b0, 1'b0, 6'h00, 32'd0, 1'b0, "R5", g);
    wr(6'h08, 32'hDEAD_BEEF, "R5");
    rd(6'h08, 1'b0, "R5 cnt", g);  chk(g == 32'd0, "R5 zeroed", g, 32'd0);
    chk(tick_irq === 1'b0, "R5 no pulse", {31'd0, tick_irq}, 32'd0);
    rd(6'h00, 1'b0, "R5 ctrl", g); chk(g == 32'h7, "R5 flag cleared", g, 32'h7);

    // Random traffic checked against the model
    for (int i = 0; i < 5000; i++) begin
      int op;
      logic rf;
      logic [31:0] d;
      op = $urandom % 12;
      rf = ($urandom % 3) == 0;
      case (op)
        0, 1: begin
          d = $urandom;
          if ($urandom % 4 != 0) d[0] = 1'b1;
          step(1'b1, 1'b1, 6'h00, d, rf, "R2", g);
        end
        2: begin
          d = ($urandom % 8 == 0) ? $urandom : ($urandom % 6);
          step(1'b1, 1'b1, 6'h04, d, rf, "R4", g);
        end
        3:    step(1'b1, 1'b1, 6'h08, $urandom, rf, "R5", g);
        4, 5: step(1'b1, 1'b0, 6'h00, 32'd0, rf, "R3 rand ctrl", g);
        6, 7: step(1'b1, 1'b0, 6'h08, 32'd0, rf, "R6 rand count", g);
        8:    step(1'b1, 1'b0, 6'h04, 32'd0, rf, "R4 rand reload", g);
        9:    step(1'b1, 1'b0, 6'h0C, 32'd0, rf, "R10 rand cal", g);
        10:   step(1'b1, ($urandom % 2) == 1, 6'($urandom), $urandom, rf, "R10 rand addr", g);
        default: step(1'b0, 1'b0, 6'h00, 32'd0, rf, "R8", g);
      endcase
    end

    summary();
    $finish;
  end

endmodule